// File: doc/BRIEF.md
# Fixed-point symmetric FIR filter

This block is an eight-tap direct-form low-pass FIR filter for signed 16-bit samples in Q4.12 format. Q4.12 means 4 integer bits, sign included, and 12 fractional bits. Each sample arrives with a valid strobe. The filter convolves the newest sample and the seven samples before it with a fixed, even-symmetric set of coefficients. It then rescales the full-precision sum back to Q4.12 and registers the result one clock after the sample is presented.

The coefficient set is symmetric, so the two taps that share a coefficient are added together before the multiply. This takes four multipliers instead of eight, and the result is the same bit for bit. Three rules fix the result exactly:
- The product width and the accumulator width leave no room for overflow.
- Rounding is half-up.
- Saturation clamps to the 16-bit range; the value never wraps.

A cycle with the valid strobe low leaves the delay line and the output untouched.

Top module: `sym_fir8`

## Requirements
- R1: A synchronous active-high reset clears the seven stored past samples, the output sample and the output valid to zero.
- R2: `out_vld` equals `in_vld` delayed by exactly one clock. The result for a sample presented at edge n is visible after edge n+1's update, that is, one cycle of latency.
- R3: When a sample is accepted, the output is round-half-up(A / 4096). A = sum over k=0..7 of c[k]·x[n-k], where x[n] is the current sample and x[n-1..n-7] are the earlier accepted samples. The coefficient integers are c = (-344, -232, 748, 1674, 1674, 748, -232, -344), indexed from newest sample to oldest. Round-half-up means floor((A + 2048) / 4096).
- R4: A rescaled value above 32767 is output as 32767, and one below -32768 is output as -32768. The value never wraps.
- R5: While `in_vld` is low, the delay line and `out_smp` hold their values. Samples presented during such a cycle are ignored.
- R6: After reset, an impulse of 1.0 (4096) followed by zeros produces the coefficient integers in order, newest-tap first, and then zero.
- R7: Whenever the output does not saturate, it stays within a tolerance of the real-valued filter that uses the coefficients -0.0841, -0.0567, 0.1826, 0.4086, 0.4086, 0.1826, -0.0567, -0.0841. The tolerance is half an LSB for rounding plus the coefficient quantization error times the input magnitudes.
- R8: The folded form, which pre-adds taps k and 7-k and uses four multipliers, produces the same full-precision sum as the unfolded eight-product sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input sample valid |
| in_smp | input | 16 | Signed Q4.12 input sample |
| out_vld | output | 1 | Output sample valid |
| out_smp | output | 16 | Signed Q4.12 filtered output |

## Verification
The assertions check four behaviours on every cycle:
- the one-cycle valid delay;
- the hold of the output while the strobe is low;
- the clamp when the rescaled sum leaves the 16-bit range;
- agreement of the folded sum with a separately computed unfolded sum.

The arithmetic value of each output can only be shown by the bench's scenarios, which compare against an integer model and a real-valued model: impulse responses over a sweep of amplitudes, steps, patterns that saturate in both directions, long pseudo-random streams with gaps in the strobe, and a reset in the middle of a stream.

// File: rtl/sym_fir8.sv
module sym_fir8 #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_smp,
  output logic                 out_vld,
  output logic signed [DW-1:0] out_smp
);
  localparam int TAPS = 8;
  localparam int HALF = TAPS / 2;
  localparam int FRAC = 12;
  localparam int PW   = DW + 1;
  localparam int MW   = PW + DW;
  localparam int AW   = MW + $clog2(TAPS);
  localparam longint MAXV = (longint'(1) << (DW - 1)) - 1;
  localparam longint MINV = -(longint'(1) << (DW - 1));
  localparam logic signed [AW-1:0] SMAX = AW'(MAXV);
  localparam logic signed [AW-1:0] SMIN = AW'(MINV);
  localparam logic signed [AW-1:0] RHALF = AW'(longint'(1) << (FRAC - 1));

  function automatic logic signed [DW-1:0] coef(input int k);
    case (k)
      0: coef = -DW'(344);
      1: coef = -DW'(232);
      2: coef = DW'(748);
      default: coef = DW'(1674);
    endcase
  endfunction

  logic signed [DW-1:0] dly [TAPS-1];
  logic signed [DW-1:0] win [TAPS];
  logic signed [MW-1:0] prod [HALF];
  logic signed [AW-1:0] acc, acc_flat, shf, sat;

  assign win[0] = in_smp;

  genvar g;
  generate
    for (g = 1; g < TAPS; g++) begin : g_win
      assign win[g] = dly[g-1];
    end
    for (g = 0; g < HALF; g++) begin : g_fold
      logic signed [PW-1:0] pre;
      assign pre     = PW'(win[g]) + PW'(win[TAPS-1-g]);
      assign prod[g] = MW'(pre) * MW'(coef(g));
    end
  endgenerate

  always_comb begin
    acc = '0;
    for (int k = 0; k < HALF; k++) acc = acc + AW'(prod[k]);
  end

  always_comb begin
    acc_flat = '0;
    for (int k = 0; k < TAPS; k++)
      acc_flat = acc_flat + AW'(win[k]) * AW'(coef(k < HALF ? k : TAPS - 1 - k));
  end

  assign shf = (acc + RHALF) >>> FRAC;
  assign sat = (shf > SMAX) ? SMAX : (shf < SMIN) ? SMIN : shf;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < TAPS - 1; k++) dly[k] <= '0;
      out_smp <= '0;
      out_vld <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        dly[0] <= in_smp;
        for (int k = 1; k < TAPS - 1; k++) dly[k] <= dly[k-1];
        out_smp <= sat[DW-1:0];
      end
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (out_smp == '0 && !out_vld));
  a_r2_valid_delay: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);
  a_r2_invalid_delay: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld);
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!in_vld && !$past(rst)) |=> $stable(out_smp));
  a_r4_clamp_hi: assert property (@(posedge clk) disable iff (rst)
    (in_vld && shf > SMAX) |=> out_smp == MAXV[DW-1:0]);
  a_r4_clamp_lo: assert property (@(posedge clk) disable iff (rst)
    (in_vld && shf < SMIN) |=> out_smp == MINV[DW-1:0]);
  a_r8_fold_match: assert property (@(posedge clk) disable iff (rst)
    acc == acc_flat);
endmodule

// File: tb/test_sym_fir8.sv
`timescale 1ns/1ps
module test_sym_fir8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic signed [15:0] in_smp = '0;
  logic out_vld;
  logic signed [15:0] out_smp;

  int total = 0;
  int bad = 0;
  bit done = 0;

  real cr [8] = '{-0.0841, -0.0567, 0.1826, 0.4086, 0.4086, 0.1826, -0.0567, -0.0841};
  longint cq [8];
  longint hist [7];
  longint last_out = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  sym_fir8 i_sym_fir8 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_smp(in_smp),
    .out_vld(out_vld), .out_smp(out_smp)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_vld = 1'b0; in_smp = '0;
    repeat (2) @(posedge clk);
    #1;
    chk(out_vld == 1'b0, "R1 valid", longint'(out_vld), 0);
    chk(out_smp == 0, "R1 sample", longint'(out_smp), 0);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 7; k++) hist[k] = 0;
    last_out = 0;
  endtask

  task automatic step(input bit v, input longint x);
    longint acc, rnd, exp;
    real fsum, tol, err;
    string tag;
    @(negedge clk);
    in_vld = v;
    in_smp = 16'(x);
    acc = cq[0] * x;
    fsum = cr[0] * real'(x);
    tol = 0.5 + 0.5 * (real'(x < 0 ? -x : x)) * 1.0e-6;
    tol = 0.5 + 0.5e-9;
    tol = tol + (real'(x < 0 ? -x : x)) * ((cr[0] * 4096.0 - real'(cq[0])) < 0 ?
          -(cr[0] * 4096.0 - real'(cq[0])) : (cr[0] * 4096.0 - real'(cq[0]))) / 4096.0;
    for (int k = 1; k < 8; k++) begin
      real d;
      acc = acc + cq[k] * hist[k-1];
      fsum = fsum + cr[k] * real'(hist[k-1]);
      d = cr[k] * 4096.0 - real'(cq[k]);
      if (d < 0) d = -d;
      tol = tol + real'(hist[k-1] < 0 ? -hist[k-1] : hist[k-1]) * d / 4096.0;
    end
    rnd = (acc + 2048) >>> 12;
    tag = "R3";
    exp = rnd;
    if (rnd > 32767) begin exp = 32767; tag = "R4 hi"; end
    if (rnd < -32768) begin exp = -32768; tag = "R4 lo"; end
    @(posedge clk);
    #1;
    chk(out_vld == v, "R2 valid delay", longint'(out_vld), longint'(v));
    if (v) begin
      chk(longint'(out_smp) == exp, tag, longint'(out_smp), exp);
      if (exp == rnd) begin
        err = real'(out_smp) - fsum;
        if (err < 0) err = -err;
        chk(err <= tol + 1.0e-6, "R7 real model", longint'(out_smp), longint'($rtoi(fsum)));
      end
      for (int k = 6; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = x;
      last_out = longint'(out_smp);
    end else begin
      chk(longint'(out_smp) == last_out, "R5 hold", longint'(out_smp), last_out);
    end
  endtask

  initial begin
    for (int k = 0; k < 8; k++)
      cq[k] = longint'($rtoi(cr[k] * 4096.0 + (cr[k] >= 0.0 ? 0.5 : -0.5)));
    do_reset();

    // R6: unit impulse gives coefficients in order
    step(1, 4096);
    chk(longint'(out_smp) == cq[0], "R6 tap0", longint'(out_smp), cq[0]);
    for (int k = 1; k < 8; k++) begin
      step(1, 0);
      chk(longint'(out_smp) == cq[k], "R6 tap", longint'(out_smp), cq[k]);
    end
    step(1, 0);
    chk(out_smp == 0, "R6 tail", longint'(out_smp), 0);

    // R3: impulse amplitude sweep
    for (int a = -32768; a < 32768; a += 257) begin
      step(1, longint'(a));
      for (int k = 0; k < 8; k++) step(1, 0);
    end

    // R3: step input
    for (int k = 0; k < 12; k++) step(1, 4096);
    for (int k = 0; k < 12; k++) step(1, 32767);

    // R4: patterns driving the sum past both limits
    for (int r = 0; r < 3; r++) begin
      step(1, -32768); step(1, -32768); step(1, 32767); step(1, 32767);
      step(1, 32767); step(1, 32767); step(1, -32768); step(1, -32768);
    end
    for (int r = 0; r < 3; r++) begin
      step(1, 32767); step(1, 32767); step(1, -32768); step(1, -32768);
      step(1, -32768); step(1, -32768); step(1, 32767); step(1, 32767);
    end

    // R5: pseudo-random stream with strobe gaps
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3] | lfsr[7], longint'($signed(lfsr)));
    end

    // R1: reset mid-stream then impulse sees a clean delay line
    for (int k = 0; k < 5; k++) step(1, 20000);
    do_reset();
    step(1, 4096);
    chk(longint'(out_smp) == cq[0], "R1 clean after reset", longint'(out_smp), cq[0]);
    for (int k = 1; k < 9; k++) step(1, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule